// File: doc/BRIEF.md
# SHA-512 Message Expansion, Partial Step

This block performs the first half of the SHA-512 message schedule update for four 64-bit words in one pass. It receives a 256-bit bus holding four consecutive schedule words, W0 to W3, and a 128-bit bus whose low word carries the following word, W4. For each lane it returns the word plus the small sigma-0 of the word one position above it. The lane-3 term therefore reaches across into the narrower bus.

A companion stage later adds the sigma-1 terms to finish the schedule words. A strobe on `in_valid` latches the four sums into a result register. `out_valid` then marks that result for exactly one cycle. While no strobe arrives, the result register keeps its last value.

Top module: `sha512_sched_p1`

## Requirements
- R1: Small sigma-0 of a 64-bit word x is (x rotated right by 1) XOR (x rotated right by 8) XOR (x shifted right by 7, filling with zeros).
- R2: Lane i of each 256-bit bus occupies bits 64*i+63 down to 64*i. The result lane i equals input lane i plus sigma-0 of input lane i+1, for i = 0, 1 and 2.
- R3: Result lane 3 (bits 255:192) equals input lane 3 plus sigma-0 of bits 63:0 of `next_i`.
- R4: Each lane sum wraps modulo 2^64, and no carry passes from one lane into the next.
- R5: Bits 127:64 of `next_i` have no effect on the result.
- R6: `out_valid` is high in exactly the cycle after an `in_valid` cycle, and `result_o` then holds the sums of the operands sampled in that `in_valid` cycle. Back-to-back strobes give back-to-back results.
- R7: In a cycle without `in_valid`, `result_o` keeps its previous value, whatever the operands do.
- R8: An asynchronous low level on `rst_n` clears `out_valid` and `result_o` to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| in_valid | input | 1 | Operand strobe; loads the result register |
| words_i | input | 256 | Four schedule words W0..W3, lane 0 in bits 63:0 |
| next_i | input | 128 | Bits 63:0 carry W4; bits 127:64 are unused |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result_o | output | 256 | Four lane sums, lane 0 in bits 63:0 |

## Verification
Presenting a new result and capturing the next operands can happen in the same cycle. The bench provokes this by driving `in_valid` on consecutive cycles with different operands each time. It then checks that every cycle shows the sums of the operands from the cycle before, and never a mix of two vectors. A second overlap is an asynchronous reset asserted while a strobe is pending. This is judged by sampling the outputs before the next edge and expecting both outputs to be zero.

// File: rtl/sms1_pkg.sv
package sms1_pkg;
  localparam int unsigned SIG_ROT_A = 1;
  localparam int unsigned SIG_ROT_B = 8;
  localparam int unsigned SIG_SHR   = 7;
endpackage

// File: rtl/sms1_sigma0.sv
module sms1_sigma0 #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned ROT_A  = 1,
  parameter int unsigned ROT_B  = 8,
  parameter int unsigned SHR_N  = 7
) (
  input  logic [WORD_W-1:0] x_i,
  output logic [WORD_W-1:0] y_o
);
  localparam int unsigned RA = ROT_A % WORD_W;
  localparam int unsigned RB = ROT_B % WORD_W;

  logic [WORD_W-1:0] rot_a;
  logic [WORD_W-1:0] rot_b;
  logic [WORD_W-1:0] shr_c;

  // Rotation built from two shifts; a zero amount degenerates cleanly.
  assign rot_a = (x_i >> RA) | (x_i << (WORD_W - RA));
  assign rot_b = (x_i >> RB) | (x_i << (WORD_W - RB));
  assign shr_c = x_i >> SHR_N;
  assign y_o   = rot_a ^ rot_b ^ shr_c;
endmodule

// File: rtl/sms1_lane.sv
module sms1_lane
  import sms1_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] succ_i,
  output logic [WORD_W-1:0] sum_o
);
  logic [WORD_W-1:0] sig;

  sms1_sigma0 #(
    .WORD_W(WORD_W),
    .ROT_A (SIG_ROT_A),
    .ROT_B (SIG_ROT_B),
    .SHR_N (SIG_SHR)
  ) u_sig (
    .x_i(succ_i),
    .y_o(sig)
  );

  // Lane-local adder: the carry out is dropped, so the sum wraps.
  assign sum_o = base_i + sig;
endmodule

// File: rtl/sms1_hold_reg.sv
module sms1_hold_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (en_i) begin
      q_nxt = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else begin
      q_o <= q_nxt;
    end
  end
endmodule

// File: rtl/sha512_sched_p1.sv
module sha512_sched_p1 #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*WORD_W-1:0] words_i,
  input  logic [2*WORD_W-1:0]     next_i,
  output logic                    out_valid,
  output logic [LANES*WORD_W-1:0] result_o
);
  localparam int unsigned BUS_W = LANES * WORD_W;

  logic [WORD_W-1:0] win [LANES+1];
  logic [BUS_W-1:0]  lane_sum;
  logic              unused_next_hi;

  // Window of LANES+1 words: the last one comes from the narrow bus.
  for (genvar g = 0; g < LANES; g++) begin : g_win
    assign win[g] = words_i[g*WORD_W +: WORD_W];
  end
  assign win[LANES] = next_i[WORD_W-1:0];
  assign unused_next_hi = ^next_i[2*WORD_W-1:WORD_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sms1_lane #(
      .WORD_W(WORD_W)
    ) u_lane (
      .base_i(win[g]),
      .succ_i(win[g+1]),
      .sum_o (lane_sum[g*WORD_W +: WORD_W])
    );
  end

  sms1_hold_reg #(
    .W(BUS_W)
  ) u_res_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (in_valid),
    .d_i  (lane_sum),
    .q_o  (result_o)
  );

  sms1_hold_reg #(
    .W(1)
  ) u_vld_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (1'b1),
    .d_i  (in_valid),
    .q_o  (out_valid)
  );
endmodule

// File: rtl/sms1_checker.sv
module sms1_checker #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [LANES*WORD_W-1:0] words_i,
  input logic [2*WORD_W-1:0]     next_i,
  input logic                    out_valid,
  input logic [LANES*WORD_W-1:0] result_o
);
  localparam int unsigned TOP_LO = (LANES - 1) * WORD_W;

  function automatic logic [WORD_W-1:0] chk_sig(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++) begin
      r[b] = x[(b + 1) % WORD_W] ^ x[(b + 8) % WORD_W] ^ ((b + 7 < WORD_W) ? x[b + 7] : 1'b0);
    end
    return r;
  endfunction

  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result_o));

  p_top_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> result_o[TOP_LO +: WORD_W] ==
      $past(words_i[TOP_LO +: WORD_W]) + chk_sig($past(next_i[WORD_W-1:0])));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && result_o == '0));
endmodule

bind sha512_sched_p1 sms1_checker #(
  .LANES (LANES),
  .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/test_sha512_sched_p1.sv
module test_sha512_sched_p1;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] words_i = '0;
  logic [127:0] next_i = '0;
  logic         out_valid;
  logic [255:0] result_o;

  int unsigned  n_total = 0;
  int unsigned  n_fail = 0;
  bit           done = 1'b0;

  logic [255:0] exp_r = '0;
  bit           exp_v = 1'b0;
  string        exp_tag = "R8";

  always #2.5 clk = ~clk;

  sha512_sched_p1 i_sha512_sched_p1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .words_i  (words_i),
    .next_i   (next_i),
    .out_valid(out_valid),
    .result_o (result_o)
  );

  function automatic logic [63:0] ref_sig(input logic [63:0] x);
    return {x[0], x[63:1]} ^ {x[7:0], x[63:8]} ^ {7'b0, x[63:7]};
  endfunction

  function automatic logic [255:0] ref_model(input logic [255:0] w, input logic [127:0] n);
    logic [63:0] wd [5];
    logic [255:0] r;
    for (int i = 0; i < 4; i++) wd[i] = w[64*i +: 64];
    wd[4] = n[63:0];
    for (int i = 0; i < 4; i++) r[64*i +: 64] = wd[i] + ref_sig(wd[i+1]);
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    chk(out_valid == exp_v, "R6 out_valid", {255'b0, out_valid}, {255'b0, exp_v});
    if (exp_v) chk(result_o == exp_r, exp_tag, result_o, exp_r);
    else       chk(result_o == exp_r, "R7 hold", result_o, exp_r);
  endtask

  // Check the previous cycle's result, then drive the next operands.
  task automatic step(input logic [255:0] w, input logic [127:0] n, input bit v, input string tag);
    @(negedge clk);
    check_out();
    words_i  = w;
    next_i   = n;
    in_valid = v;
    if (v) exp_r = ref_model(w, n);
    exp_v   = v;
    exp_tag = tag;
  endtask

  initial begin
    #(5.0 * 150000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs cleared during reset
    chk(out_valid == 1'b0, "R8 reset valid", {255'b0, out_valid}, '0);
    chk(result_o == '0, "R8 reset data", result_o, '0);
    rst_n = 1'b1;

    // R1: single-bit words across every bit position, back to back
    for (int b = 0; b < 64; b++) begin
      logic [255:0] w;
      for (int l = 0; l < 4; l++) w[64*l +: 64] = 64'd1 << ((b + 16*l) % 64);
      step(w, {64'd0, 64'd1 << ((b + 7) % 64)}, 1'b1, "R1 single-bit");
    end

    // R2: one lane non-zero at a time, sigma feeds only the lane below
    for (int l = 0; l < 4; l++) begin
      for (int k = 0; k < 8; k++) begin
        logic [255:0] w;
        w = '0;
        w[64*l +: 64] = rnd64();
        step(w, '0, 1'b1, "R2 lane map");
      end
    end

    // R3: only the narrow bus low word varies
    for (int k = 0; k < 32; k++) step('0, {64'd0, rnd64()}, 1'b1, "R3 top lane");

    // R4: all-ones operands force wrap-around in every lane
    step({256{1'b1}}, {128{1'b1}}, 1'b1, "R4 all-ones");
    step({4{64'hFFFF_FFFF_FFFF_FFFF}}, {64'h0, 64'h8000_0000_0000_0000}, 1'b1, "R4 wrap");
    for (int k = 0; k < 16; k++) begin
      logic [255:0] w;
      for (int l = 0; l < 4; l++) w[64*l +: 64] = 64'hFFFF_FFFF_0000_0000 | rnd64();
      step(w, {rnd64(), rnd64()}, 1'b1, "R4 carry isolation");
    end

    // R5: upper half of narrow bus toggled, low word held
    begin
      logic [255:0] w;
      logic [63:0]  lo;
      w = {rnd64(), rnd64(), rnd64(), rnd64()};
      lo = rnd64();
      for (int k = 0; k < 16; k++) step(w, {rnd64(), lo}, 1'b1, "R5 upper ignored");
      step(w, {64'hFFFF_FFFF_FFFF_FFFF, lo}, 1'b1, "R5 upper ones");
    end

    // R6/R7: sparse strobes with operands churning while idle
    for (int k = 0; k < 40; k++) begin
      bit v;
      v = (k % 3) == 0;
      step({rnd64(), rnd64(), rnd64(), rnd64()}, {rnd64(), rnd64()}, v, "R6 sparse");
    end

    // R1: long random back-to-back run
    for (int k = 0; k < 300; k++)
      step({rnd64(), rnd64(), rnd64(), rnd64()}, {rnd64(), rnd64()}, 1'b1, "R1 random");

    // R8: asynchronous reset landing on a pending strobe
    @(negedge clk);
    check_out();
    words_i  = {rnd64(), rnd64(), rnd64(), rnd64()};
    in_valid = 1'b1;
    #1 rst_n = 1'b0;
    #0.5;
    chk(out_valid == 1'b0, "R8 async valid", {255'b0, out_valid}, '0);
    chk(result_o == '0, "R8 async data", result_o, '0);
    in_valid = 1'b0;
    exp_v = 1'b0;
    exp_r = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step('0, '0, 1'b0, "R8 after reset");
    step('0, '0, 1'b0, "R8 after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule